// File: doc/BRIEF.md
# Byte-Offset Windowed Transfer Register Reader

This block holds a small bank of 32-bit transfer registers that any of eight hardware threads can fill and read. Instead of word-addressed reads, it reads through a run-time pointer that carries a byte offset into the bank. One control write sets the pointer. Each read strobe returns a 32-bit big-endian window that begins at the pointer's byte position and may run into the following register. The pointer then moves forward by one word, so a burst of reads walks through a header that starts at an arbitrary byte.

A newly written pointer does not act at once. It passes through a fixed load latency, and `idx_ready` shows when the new value is in force. Reads issued during that latency still use the previous pointer. The intended use is parsing: software locates a field at run time, loads its byte offset, waits for `idx_ready`, and then streams right-justified words out with back-to-back reads.

Top module: `idx_byte_reader`

## Requirements
- R1: A synchronous active-high `rst` clears every register to 0 and sets the pointer to offset 0. In the cycle after reset, `idx_ready` is 1, `rd_valid` is 0 and `rd_data` is 0.
- R2: When `wr_en` is sampled high, `wr_data` is stored in register `wr_addr` (0 to 7). Every register can be written and later read.
- R3: The 5-bit pointer offset splits into a register number in bits 4:2 and a byte position in bits 1:0. Byte position 0 is bits 31:24 of a register and position 3 is bits 7:0. For example, offset 0x09 means register 2, byte 1.
- R4: A read returns the four bytes that start at the pointer's byte offset, with the first byte in `rd_data[31:24]`. When the byte position is not 0, the trailing bytes come from the next register.
- R5: When the byte position is 0, a read returns the selected register unchanged and takes nothing from the next register.
- R6: When the window starts in register 7 and crosses a word boundary, the remaining bytes come from register 0.
- R7: Each read adds one to the register number, modulo 8, and leaves the byte position as it was. Consecutive reads therefore return consecutive 4-byte windows.
- R8: `idx_ready` falls in the cycle after `idx_wr` is sampled high and rises again 3 cycles after that sample. Reads sampled while `idx_ready` is low use, and advance, the previous pointer. The new offset takes over at the edge where `idx_ready` rises.
- R9: `rd_valid` is high exactly in the cycle after `rd_en` is sampled high, with `rd_data` updated in that same cycle. Otherwise `rd_valid` is low and `rd_data` holds its value.
- R10: If a write and a read hit the same register at the same edge, the read returns the data held before the write.
- R11: An `idx_wr` sampled while an earlier load is still pending discards the earlier offset and restarts the 3-cycle latency with the newer offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register number to write |
| wr_data | input | 32 | Data to write |
| idx_wr | input | 1 | Pointer load strobe |
| idx_offset | input | 5 | Byte offset to load (register in 4:2, byte in 1:0) |
| rd_en | input | 1 | Indexed read strobe |
| rd_data | output | 32 | Byte-aligned read window |
| rd_valid | output | 1 | High in the cycle after a read is sampled |
| idx_ready | output | 1 | High when no pointer load is pending |

## Verification
The bench fills the bank with a byte-numbered pattern so every window value names its source bytes. It aims at windows that start in register 7: a design that failed to wrap would return bytes from a nonexistent ninth word or from register 7 again. It issues reads inside the load latency and a second load during a pending one. A design with the wrong latency, or one that kept the stale pending offset, would show the new window too early or read from the wrong register. Same-edge write and read to one register, and offsets that are multiples of four, catch a read that bypasses new data and an aligner that pulls bytes from the neighbour when it should not.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int NUM_REGS = 8;
  localparam int DATA_W   = 32;
  localparam int BYTES    = DATA_W / 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int BYTE_W   = $clog2(BYTES);
  localparam int OFF_W    = IDX_W + BYTE_W;

  // Strobes passed from pointer control to the datapath
  typedef struct packed {
    logic              rdFire;
    logic [IDX_W-1:0]  wordSel;
    logic [BYTE_W-1:0] byteSel;
  } rd_strobe_t;
endpackage

// File: rtl/ibr_idx_ctrl.sv
module ibr_idx_ctrl
  import ibr_pkg::*;
#(
  parameter int LOAD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdEn,
  input  logic             idxWr,
  input  logic [OFF_W-1:0] idxOffset,
  output rd_strobe_t       strb,
  output logic             idxReady
);
  localparam int CNT_W = $clog2(LOAD_LAT + 1);

  logic [IDX_W-1:0]  curWord;
  logic [BYTE_W-1:0] curByte;
  logic [OFF_W-1:0]  pendOff;
  logic [CNT_W-1:0]  pendCnt;
  logic              pending;
  logic [IDX_W-1:0]  stepWord;

  assign stepWord = rdEn ? IDX_W'(curWord + 1'b1) : curWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      curWord  <= '0;
      curByte  <= '0;
      pendOff  <= '0;
      pendCnt  <= '0;
      pending  <= 1'b0;
      idxReady <= 1'b1;
    end else begin
      curWord <= stepWord;
      if (idxWr) begin
        pending  <= 1'b1;
        pendOff  <= idxOffset;
        pendCnt  <= CNT_W'(LOAD_LAT - 1);
        idxReady <= 1'b0;
      end else if (pending) begin
        if (pendCnt == '0) begin
          curWord  <= pendOff[OFF_W-1:BYTE_W];
          curByte  <= pendOff[BYTE_W-1:0];
          pending  <= 1'b0;
          idxReady <= 1'b1;
        end else begin
          pendCnt <= pendCnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.rdFire  = rdEn;
    strb.wordSel = curWord;
    strb.byteSel = curByte;
  end
endmodule

// File: rtl/ibr_aligner.sv
module ibr_aligner
  import ibr_pkg::*;
(
  input  logic [DATA_W-1:0] hiWord,
  input  logic [DATA_W-1:0] loWord,
  input  logic [BYTE_W-1:0] byteSel,
  output logic [DATA_W-1:0] window
);
  logic [2*DATA_W-1:0] pair;
  assign pair = {hiWord, loWord};

  // One byte lane per output position; lane k takes pair byte byteSel+k
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    logic [BYTE_W:0] src;
    assign src = {1'b0, byteSel} + (BYTE_W+1)'(k);
    assign window[DATA_W-1-8*k -: 8] = pair[(2*BYTES-1-int'(src))*8 +: 8];
  end
endmodule

// File: rtl/ibr_datapath.sv
module ibr_datapath
  import ibr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  rd_strobe_t        strb,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic [DATA_W-1:0] bank [NUM_REGS];
  logic [IDX_W-1:0]  nextWord;
  logic [DATA_W-1:0] window;

  assign nextWord = IDX_W'(strb.wordSel + 1'b1);

  ibr_aligner u_align (
    .hiWord (bank[strb.wordSel]),
    .loWord (bank[nextWord]),
    .byteSel(strb.byteSel),
    .window (window)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else if (wrEn) begin
      bank[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdFire;
      if (strb.rdFire) rdData <= window;
    end
  end
endmodule

// File: rtl/idx_byte_reader.sv
module idx_byte_reader
  import ibr_pkg::*;
#(
  parameter int LOAD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              idx_wr,
  input  logic [OFF_W-1:0]  idx_offset,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              idx_ready
);
  rd_strobe_t strb;

  ibr_idx_ctrl #(.LOAD_LAT(LOAD_LAT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rdEn     (rd_en),
    .idxWr    (idx_wr),
    .idxOffset(idx_offset),
    .strb     (strb),
    .idxReady (idx_ready)
  );

  ibr_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wr_en),
    .wrAddr (wr_addr),
    .wrData (wr_data),
    .strb   (strb),
    .rdData (rd_data),
    .rdValid(rd_valid)
  );
endmodule

// File: rtl/ibr_checker.sv
module ibr_checker
  import ibr_pkg::*;
#(
  parameter int LOAD_LAT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              idx_wr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              idx_ready
);
  int sinceLoad;

  always_ff @(posedge clk) begin
    if (rst) sinceLoad <= LOAD_LAT;
    else if (idx_wr) sinceLoad <= 0;
    else if (sinceLoad < LOAD_LAT) sinceLoad <= sinceLoad + 1;
  end

  // R1: clean outputs after reset
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (idx_ready && !rd_valid && rd_data == '0));

  // R8: ready only once the full latency has passed since the last load
  p_ready_window_r8: assert property (@(posedge clk) disable iff (rst)
    idx_ready == (sinceLoad == LOAD_LAT));

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> !idx_ready);

  // R9: valid follows the read strobe by one cycle, data held otherwise
  p_valid_after_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind idx_byte_reader ibr_checker #(.LOAD_LAT(LOAD_LAT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .idx_wr   (idx_wr),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .idx_ready(idx_ready)
);

// File: tb/idx_byte_reader_bench.sv
`timescale 1ns/1ps
module idx_byte_reader_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        idx_wr;
  logic [4:0]  idx_offset;
  logic        rd_en;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        idx_ready;

  always #2.5 clk = ~clk;

  idx_byte_reader u_idx_byte_reader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idx_wr(idx_wr), .idx_offset(idx_offset), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .idx_ready(idx_ready)
  );

  // Reference model built from the requirements
  logic [31:0] mMem [8];
  logic [2:0]  mW;
  logic [1:0]  mB;
  logic        mPend;
  logic [4:0]  mPOff;
  int          mCnt;
  logic        mReady;
  logic        mV;
  logic [31:0] mData;

  int    checks = 0;
  int    errors = 0;
  string tag = "R4";
  bit    done = 0;

  function automatic logic [31:0] window(logic [2:0] w, logic [1:0] b);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int pos = (int'(w) * 4 + int'(b) + k) % 32;
      logic [31:0] word = mMem[pos / 4];
      r = {r[23:0], word[31 - 8 * (pos % 4) -: 8]};
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [2:0] nextW;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 8; i++) mMem[i] = '0;
      mW = 0; mB = 0; mPend = 0; mPOff = 0; mCnt = 0;
      mReady = 1; mV = 0; mData = 0;
    end else begin
      nextW = mW;
      if (rd_en) begin
        mData = window(mW, mB);
        mV = 1;
        nextW = mW + 3'd1;
      end else mV = 0;
      if (idx_wr) begin
        mPend = 1; mPOff = idx_offset; mCnt = 2; mReady = 0; mW = nextW;
      end else if (mPend) begin
        if (mCnt == 0) begin
          mW = mPOff[4:2]; mB = mPOff[1:0]; mPend = 0; mReady = 1;
        end else begin
          mCnt--; mW = nextW;
        end
      end else mW = nextW;
      if (wr_en) mMem[wr_addr] = wr_data;
    end
    #1;
    check("R9", {31'd0, rd_valid}, {31'd0, mV});
    check("R8", {31'd0, idx_ready}, {31'd0, mReady});
    if (mV) check(tag, rd_data, mData);
  endtask

  task automatic loadIdx(logic [4:0] off);
    idx_wr = 1; idx_offset = off; step();
    idx_wr = 0;
    repeat (3) step();
    check("R8 ready", {31'd0, idx_ready}, 32'd1);
  endtask

  task automatic rd(string t, logic [31:0] exp);
    tag = t; rd_en = 1; step(); rd_en = 0;
    check(t, rd_data, exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    idx_wr = 0; idx_offset = 0; rd_en = 0;
    tag = "R1";
    step(); step();
    rst = 0;
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 ready", {31'd0, idx_ready}, 32'd1);
    rd("R1", 32'h0);

    // R2: byte-numbered fill
    for (int r = 0; r < 8; r++) begin
      wr_en = 1; wr_addr = 3'(r);
      wr_data = {8'(4*r), 8'(4*r+1), 8'(4*r+2), 8'(4*r+3)};
      step();
    end
    wr_en = 0;
    loadIdx(5'h00);
    rd("R2", 32'h00010203);

    // R3 / R4 / R7: offset 0x09 then post-increment
    loadIdx(5'h09);
    rd("R3", 32'h090a0b0c);
    rd("R7", 32'h0d0e0f10);
    rd("R4", 32'h11121314);

    // R6: wrap from register 7 to register 0
    loadIdx(5'h1d);
    rd("R6", 32'h1d1e1f00);
    rd("R7", 32'h01020304);

    // R5: aligned offsets take nothing from the next register
    loadIdx(5'h1c);
    rd("R5", 32'h1c1d1e1f);
    rd("R6", 32'h00010203);

    // R8: reads during latency use the old pointer (now register 1, byte 0)
    idx_wr = 1; idx_offset = 5'h06; step(); idx_wr = 0;
    rd("R8", 32'h04050607);
    rd("R8", 32'h08090a0b);
    rd("R8", 32'h0c0d0e0f);
    rd("R8", 32'h06070809);

    // R11: a second load while pending replaces the first
    idx_wr = 1; idx_offset = 5'h08; step();
    idx_offset = 5'h13; step(); idx_wr = 0;
    repeat (2) step();
    check("R11 not ready", {31'd0, idx_ready}, 32'd0);
    step();
    rd("R11", 32'h13141516);

    // R10: same-edge write and read of register 3
    loadIdx(5'h0c);
    tag = "R10"; rd_en = 1; wr_en = 1; wr_addr = 3'd3; wr_data = 32'hdeadbeef;
    step(); rd_en = 0; wr_en = 0;
    check("R10", rd_data, 32'h0c0d0e0f);
    loadIdx(5'h0c);
    rd("R2", 32'hdeadbeef);

    // Random phase
    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      rst        = ($urandom % 500) == 0;
      rd_en      = ($urandom % 2) == 0;
      wr_en      = ($urandom % 10) < 3;
      wr_addr    = 3'($urandom);
      wr_data    = $urandom;
      idx_wr     = ($urandom % 10) == 0;
      idx_offset = 5'($urandom);
      step();
    end
    rst = 0; rd_en = 0; wr_en = 0; idx_wr = 0;
    step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule